// File: doc/BRIEF.md
# Ready-Time Ordered Transmit Queue

This block is the outgoing queue of one direction of a store-and-forward link. Every entry carries a time stamp taken from a free-running cycle counter inside the block: the cycle from which the entry may be sent. Ordinary forwarded traffic always joins at the tail and becomes sendable a fixed forward delay after it was pushed. Negative acknowledgements (NACKs) use their own delay, normally shorter. Such an entry is placed so that it overtakes later-stamped entries while keeping arrival order among equal stamps. The whole placement, including the shift of the younger entries, happens in the push cycle.

The head entry is presented on a valid/ready output once its stamp has been reached. A refusal by the downstream port (valid high, ready low) parks the queue. It presents nothing until the downstream pulses a retry. After that the head is offered again as soon as it is due. Time stamps are compared modulo the counter width, so no entry may wait longer than half the counter range.

Top module: `ready_tx_queue`

## Requirements
- R1: While reset is high and in the first cycle after it, `tx_valid` and `full` are low and the queue is empty.
- R2: A push with `push_kind` = 0 (forward) appends the entry at the tail with a stamp of the push cycle plus `FWD_DELAY`. If it reaches the head, it is first offered in that stamped cycle.
- R3: A push with `push_kind` = 1 (NACK) stamps the entry with the push cycle plus `NACK_DELAY`. It is appended at the tail when the queue is empty or when its stamp is not earlier than the tail's stamp.
- R4: A NACK whose stamp is earlier than the tail's is inserted just before the oldest entry whose stamp is strictly later. Entries with equal stamps keep arrival order. A NACK that lands at the head is offered at its own stamp.
- R5: `tx_valid` is high only when the queue is non-empty, the head's stamp has been reached and the queue is not parked.
- R6: A cycle with `tx_valid` high and `tx_ready` low is a refusal. From the next cycle on, `tx_valid` stays low and the head is kept until a cycle with `tx_retry` high.
- R7: A `tx_retry` cycle while parked unparks the queue, and the due head is offered in the next cycle. A `tx_retry` while not parked has no effect.
- R8: A cycle with `tx_valid` and `tx_ready` both high removes the head. The next entry is offered no earlier than the following cycle and no earlier than its own stamp.
- R9: `full` is high while `DEPTH` entries are held. A push in a cycle with `full` high is discarded and leaves the queue unchanged.
- R10: A push and a send in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Push an entry this cycle |
| push_kind | input | 1 | 0 = forward entry, 1 = NACK entry |
| push_data | input | TQ_DATA_W | Payload of the pushed entry |
| full | output | 1 | Queue holds DEPTH entries |
| tx_valid | output | 1 | Head entry offered downstream |
| tx_data | output | TQ_DATA_W | Payload of the head entry |
| tx_ready | input | 1 | Downstream accepts the offered entry |
| tx_retry | input | 1 | Downstream invites a new attempt after a refusal |

## Verification
The bench builds the queue with `DEPTH` = 4, `FWD_DELAY` = 6 and `NACK_DELAY` = 2. Because the NACK delay is shorter, a NACK pushed a few cycles after forward entries lands at the head or in the middle, and a NACK can tie with a forward stamp, which exercises the equal-stamp ordering. With a depth of 4 below a forward delay of 6, a burst of pushes fills the queue before anything is due, so discarded pushes and a push together with a send in one cycle come up in both directed and pseudo-random traffic. Refusals and retries are mixed in against a behavioural queue model that is compared every cycle.

// File: rtl/tq_pkg.sv
package tq_pkg;

    localparam int TQ_TIME_W = 16;
    localparam int TQ_DATA_W = 8;

    typedef logic [TQ_TIME_W-1:0] tq_time_t;
    typedef logic [TQ_DATA_W-1:0] tq_data_t;

    typedef enum logic {
        TQ_KIND_FWD  = 1'b0,
        TQ_KIND_NACK = 1'b1
    } tq_kind_e;

    typedef struct packed {
        tq_data_t data;
        tq_time_t rdy;
    } tq_entry_t;

    // stamp has been reached (modulo counter width)
    function automatic logic tq_due(input tq_time_t now, input tq_time_t rdy);
        tq_time_t diff;
        diff = now - rdy;
        return ~diff[TQ_TIME_W-1];
    endfunction

    // a is strictly later than b (modulo counter width)
    function automatic logic tq_after(input tq_time_t a, input tq_time_t b);
        tq_time_t diff;
        diff = a - b;
        return (diff != '0) && ~diff[TQ_TIME_W-1];
    endfunction

endpackage

// File: rtl/tq_timebase.sv
module tq_timebase
    import tq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    output tq_time_t now
);

    always_ff @(posedge clk) begin
        if (rst) begin
            now <= '0;
        end else begin
            now <= now + tq_time_t'(1);
        end
    end

endmodule

// File: rtl/tq_place.sv
module tq_place
    import tq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  tq_entry_t [DEPTH-1:0] view,
    input  logic [CW-1:0]         cnt_a,
    input  tq_time_t              new_rdy,
    input  tq_kind_e              kind,
    output logic [CW-1:0]         pos
);

    logic [DEPTH-1:0] live_v;
    logic [DEPTH-1:0] later_v;
    logic             tail_later;
    logic             found;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign live_v[g]  = (CW'(g) < cnt_a);
        assign later_v[g] = tq_after(view[g].rdy, new_rdy);
    end

    // is the tail stamp strictly later than the new stamp?
    always_comb begin
        tail_later = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i + 1) == cnt_a) begin
                tail_later = later_v[i];
            end
        end
    end

    always_comb begin
        pos   = cnt_a;
        found = 1'b0;
        if (kind == TQ_KIND_NACK && tail_later) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!found && live_v[i] && later_v[i]) begin
                    pos   = CW'(i);
                    found = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tq_store.sv
module tq_store
    import tq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pop,
    input  logic                  ins,
    input  tq_entry_t             ins_ent,
    input  logic [CW-1:0]         ins_pos,
    output tq_entry_t [DEPTH-1:0] ent_q,
    output logic [CW-1:0]         cnt_q,
    output tq_entry_t [DEPTH-1:0] view,
    output logic [CW-1:0]         cnt_a
);

    tq_entry_t [DEPTH-1:0] ent_d;

    assign cnt_a = cnt_q - CW'(pop);

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        // contents after the optional removal of the head
        if (g == DEPTH - 1) begin : g_last
            assign view[g] = pop ? '0 : ent_q[g];
        end else begin : g_mid
            assign view[g] = pop ? ent_q[g+1] : ent_q[g];
        end

        // contents after the optional insertion
        if (g == 0) begin : g_first
            always_comb begin
                ent_d[g] = view[g];
                if (ins && ins_pos == CW'(g)) begin
                    ent_d[g] = ins_ent;
                end
            end
        end else begin : g_rest
            always_comb begin
                ent_d[g] = view[g];
                if (ins) begin
                    if (ins_pos == CW'(g)) begin
                        ent_d[g] = ins_ent;
                    end else if (ins_pos < CW'(g)) begin
                        ent_d[g] = view[g-1];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q <= '0;
            cnt_q <= '0;
        end else begin
            ent_q <= ent_d;
            cnt_q <= cnt_a + CW'(ins);
        end
    end

endmodule

// File: rtl/ready_tx_queue.sv
module ready_tx_queue
    import tq_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int FWD_DELAY  = 6,
    parameter int NACK_DELAY = 2,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 push_valid,
    input  logic                 push_kind,
    input  logic [TQ_DATA_W-1:0] push_data,
    output logic                 full,
    output logic                 tx_valid,
    output logic [TQ_DATA_W-1:0] tx_data,
    input  logic                 tx_ready,
    input  logic                 tx_retry
);

    tq_time_t              now_t;
    tq_entry_t [DEPTH-1:0] ent_q;
    tq_entry_t [DEPTH-1:0] view;
    logic [CW-1:0]         cnt_q;
    logic [CW-1:0]         cnt_a;
    logic [CW-1:0]         ins_pos;
    tq_time_t              head_rdy;
    tq_entry_t             new_ent;
    tq_kind_e              kind;
    logic                  parked_q;
    logic                  head_due;
    logic                  pop;
    logic                  refuse;
    logic                  accept;

    tq_timebase u_time (
        .clk (clk),
        .rst (rst),
        .now (now_t)
    );

    assign kind         = tq_kind_e'(push_kind);
    assign head_rdy     = ent_q[0].rdy;
    assign head_due     = (cnt_q != '0) && tq_due(now_t, head_rdy);
    assign tx_valid     = head_due && !parked_q;
    assign tx_data      = ent_q[0].data;
    assign pop          = tx_valid && tx_ready;
    assign refuse       = tx_valid && !tx_ready;
    assign full         = (cnt_q == CW'(DEPTH));
    assign accept       = push_valid && !full;
    assign new_ent.data = push_data;
    assign new_ent.rdy  = now_t + ((kind == TQ_KIND_NACK) ? tq_time_t'(NACK_DELAY)
                                                          : tq_time_t'(FWD_DELAY));

    tq_place #(.DEPTH(DEPTH)) u_place (
        .view    (view),
        .cnt_a   (cnt_a),
        .new_rdy (new_ent.rdy),
        .kind    (kind),
        .pos     (ins_pos)
    );

    tq_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .pop     (pop),
        .ins     (accept),
        .ins_ent (new_ent),
        .ins_pos (ins_pos),
        .ent_q   (ent_q),
        .cnt_q   (cnt_q),
        .view    (view),
        .cnt_a   (cnt_a)
    );

    // parked after a refusal until the downstream invites a retry
    always_ff @(posedge clk) begin
        if (rst) begin
            parked_q <= 1'b0;
        end else if (refuse) begin
            parked_q <= 1'b1;
        end else if (tx_retry) begin
            parked_q <= 1'b0;
        end
    end

endmodule

// File: rtl/tq_checker.sv
module tq_checker
    import tq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic          tx_retry,
    input logic          full,
    input logic          push_valid,
    input tq_time_t      now,
    input tq_time_t      head_rdy,
    input logic [CW-1:0] cnt
);

    logic waiting;

    always_ff @(posedge clk) begin
        if (rst) begin
            waiting <= 1'b0;
        end else if (tx_valid && !tx_ready) begin
            waiting <= 1'b1;
        end else if (tx_retry) begin
            waiting <= 1'b0;
        end
    end

    AST_OFFER_DUE: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (cnt != '0) && tq_due(now, head_rdy)); // R5

    AST_REFUSE_PARKS: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> !tx_valid); // R6

    AST_PARKED_SILENT: assert property (@(posedge clk) disable iff (rst)
        waiting |-> !tx_valid); // R6

    AST_RETRY_RESUME: assert property (@(posedge clk) disable iff (rst)
        (waiting && tx_retry) |=> tx_valid); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH)); // R9

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (full && push_valid && !(tx_valid && tx_ready)) |=> full); // R9

endmodule

bind ready_tx_queue tq_checker #(.DEPTH(DEPTH)) u_tq_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_retry   (tx_retry),
    .full       (full),
    .push_valid (push_valid),
    .now        (now_t),
    .head_rdy   (head_rdy),
    .cnt        (cnt_q)
);

// File: tb/ready_tx_queue_test.sv
module ready_tx_queue_test;
    import tq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int FWD        = 6;
    localparam int NACK       = 2;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 push_valid = 1'b0;
    logic                 push_kind = 1'b0;
    logic [TQ_DATA_W-1:0] push_data = '0;
    logic                 full;
    logic                 tx_valid;
    logic [TQ_DATA_W-1:0] tx_data;
    logic                 tx_ready = 1'b0;
    logic                 tx_retry = 1'b0;

    typedef struct {
        int d;
        int rdy;
    } m_t;

    m_t    mq[$];
    int    mnow = 1;
    bit    mwait = 1'b0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R1";
    int    lfsr = 32'h1ACE5EED;

    ready_tx_queue #(.DEPTH(DEPTH), .FWD_DELAY(FWD), .NACK_DELAY(NACK)) uut (
        .clk        (clk),
        .rst        (rst),
        .push_valid (push_valid),
        .push_kind  (push_kind),
        .push_data  (push_data),
        .full       (full),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_ready   (tx_ready),
        .tx_retry   (tx_retry)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    // one clock: drive inputs, compare against the model, advance the model
    task automatic step(input bit v, input bit k, input int d, input bit rd, input bit rt);
        bit ev, ef, send, refuse, acc;
        int r, pos;
        @(negedge clk);
        push_valid = v;
        push_kind  = k;
        push_data  = d[7:0];
        tx_ready   = rd;
        tx_retry   = rt;
        #1;
        ev = (mq.size() > 0) && !mwait && (mnow >= mq[0].rdy);
        ef = (mq.size() == DEPTH);
        check(tx_valid === ev, "tx_valid", int'(tx_valid), int'(ev));
        check(full === ef, "full", int'(full), int'(ef));
        if (ev) check(int'(tx_data) == (mq[0].d & 255), "tx_data", int'(tx_data), mq[0].d & 255);
        send   = ev && rd;
        refuse = ev && !rd;
        acc    = v && !ef;
        if (refuse) mwait = 1'b1;
        else if (rt) mwait = 1'b0;
        if (send) void'(mq.pop_front());
        if (acc) begin
            if (!k) begin
                r = mnow + FWD;
                mq.push_back('{d & 255, r});
            end else begin
                r = mnow + NACK;
                if (mq.size() == 0 || r >= mq[mq.size()-1].rdy) begin
                    mq.push_back('{d & 255, r});
                end else begin
                    pos = 0;
                    while (mq[pos].rdy <= r) pos++;
                    mq.insert(pos, '{d & 255, r});
                end
            end
        end
        mnow++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 1, 1);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        #1;
        check(tx_valid === 1'b0, "tx_valid in reset", int'(tx_valid), 0);
        check(full === 1'b0, "full in reset", int'(full), 0);
        @(negedge clk);
        rst = 1'b0;
        step(0, 0, 0, 1, 0);

        // R2: forward entry offered FWD cycles after push
        cur_req = "R2";
        step(1, 0, 8'h11, 1, 0);
        idle(9);

        // R3: NACK into empty queue, then NACK not earlier than tail
        cur_req = "R3";
        step(1, 1, 8'h21, 1, 0);
        idle(4);
        step(1, 0, 8'h22, 1, 0);
        idle(4);
        step(1, 1, 8'h23, 1, 0);
        idle(8);

        // R4: NACK overtaking to the head, and NACK tying a middle stamp
        cur_req = "R4";
        step(1, 0, 8'h31, 1, 0);
        step(1, 0, 8'h32, 1, 0);
        step(1, 0, 8'h33, 1, 0);
        step(1, 1, 8'h34, 1, 0);
        step(0, 0, 0, 1, 0);
        step(1, 1, 8'h35, 1, 0);
        idle(10);

        // R5: nothing offered before the stamp while downstream is ready
        cur_req = "R5";
        step(1, 0, 8'h41, 1, 0);
        for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 0);

        // R6: refusal parks the queue; ready alone does not resume
        cur_req = "R6";
        step(1, 0, 8'h51, 0, 0);
        step(1, 0, 8'h52, 0, 0);
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0);

        // R7: retry resumes; retry while not parked changes nothing
        cur_req = "R7";
        step(0, 0, 0, 1, 1);
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 1, 1);
        step(0, 0, 0, 1, 0);
        idle(4);

        // R8: back-to-back entries go out one per cycle
        cur_req = "R8";
        step(1, 0, 8'h61, 1, 0);
        step(1, 0, 8'h62, 1, 0);
        step(1, 0, 8'h63, 1, 0);
        idle(10);

        // R9: fill, push while full is dropped
        cur_req = "R9";
        for (int i = 0; i < 6; i++) step(1, i[0], 8'h70 + i, 1, 0);
        idle(12);

        // R10: continuous pushes while sending
        cur_req = "R10";
        for (int i = 0; i < 24; i++) step(1, 0, 8'h80 + i, 1, 0);
        idle(12);

        // mixed traffic covering all requirements
        cur_req = "R4";
        for (int i = 0; i < 600; i++) begin
            lfsr = (lfsr << 1) ^ ((lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]) ? 1 : 0);
            step(lfsr[3], lfsr[7] & lfsr[5], lfsr[19:12], lfsr[9] | lfsr[10],
                 lfsr[11] & lfsr[13]);
        end
        idle(20);

        summary();
    end

endmodule